// File: doc/BRIEF.md
# Internal Processor Register Access Unit

This block holds the privileged control registers of a processor core. These are 64-bit registers selected by an 8-bit index. Privileged code reaches them through two operations: a move-to (write strobe) and a move-from (read strobe). A register is more than plain storage. Each one has its own write mask, and some have a behaviour of their own:

- it clears when written,
- it can only be read,
- it can only be written, or
- reading it has a side effect.

An index that is not implemented, or an access in the wrong direction, raises a fault that the core turns into an unimplemented-opcode trap.

Accesses last one cycle. Read data, the fault flag and the side-effect pulses are all registered, so they appear in the cycle after the strobe. The side-effect pulses go to neighbouring logic:

- an interrupt-status unlock, and
- for the data and the instruction translation buffers, invalidate-all, invalidate-process and invalidate-single commands. The invalidate-single command comes with the address that was written.

Top module: `ipr_unit`

## Requirements
- R1: After reset the privileged base register (index 0x18) reads `PBASE_RST` and the mode control register (0x24) reads 0x6. Every other readable register reads zero. All outputs are low.
- R2: Scratch registers 0x00 to 0x17, the privileged base register 0x18 and the mode control register 0x24 store all 64 written bits. A legal read presents data on `rd_data` in the cycle after the strobe. `rd_data` is zero in any cycle that follows no legal read.
- R3: A write to the exception-address register 0x19 stores the data with bit 1 forced to zero.
- R4: Narrow registers keep only the bits of their mask:
  - AST request 0x1A and AST enable 0x1B keep 0xf.
  - Interrupt level 0x1C keeps 0x1f.
  - Current mode 0x1D keeps 0x18.
  - Software interrupt request 0x1F keeps 0x7fff0.
  - Cache mode 0x20 and miss-buffer mode 0x21 keep 0x3f.
- R5: Any write to the exception summary 0x22 or the exception mask 0x23 completes without fault and leaves the register reading zero.
- R6: The read-only registers are fault address 0x25, interrupt ID 0x26, memory-management status 0x27 and serial receive 0x28. A write to any of them raises `acc_fault` and changes nothing. A read of them returns zero without fault.
- R7: The write-only registers are alternate mode 0x1E, hardware interrupt clear 0x29, data-cache flush 0x2A, instruction-cache flush 0x2B and the invalidate registers 0x2C to 0x31. Writing them completes without fault. Reading them raises `acc_fault` with `rd_data` zero.
- R8: An unused index raises `acc_fault` on a read or a write. Unused indices are 0x32 and above, plus scratch indices at or above `NUM_SCRATCH`. A strobe with read and write both high also faults and has no effect on any register.
- R9: A read of the fault address register 0x25 pulses `intr_unlock_p` in the cycle after the strobe.
- R10: A write to invalidate-all pulses `tlb_inv_all_p`, and a write to invalidate-process pulses `tlb_inv_proc_p`:
  - 0x2C and 0x2D drive bit 0 (data buffer).
  - 0x2F and 0x30 drive bit 1 (instruction buffer).
- R11: A write to invalidate-single pulses `tlb_inv_one_p`: 0x2E drives bit 0 and 0x31 drives bit 1. In the same cycle, `tlb_inv_va` presents the written value.
- R12: Every side-effect pulse is high for exactly one cycle, and at most one pulse is high at a time. No pulse is raised by an access that faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_idx | input | 8 | Register index |
| acc_wdata | input | 64 | Move-to data |
| acc_rd | input | 1 | Move-from strobe |
| acc_wr | input | 1 | Move-to strobe |
| rd_data | output | 64 | Move-from result, one cycle after the strobe |
| acc_fault | output | 1 | Unimplemented-opcode fault for the previous access |
| intr_unlock_p | output | 1 | Interrupt-status unlock pulse |
| tlb_inv_all_p | output | 2 | Invalidate-all pulse (bit 0 data, bit 1 instruction) |
| tlb_inv_proc_p | output | 2 | Invalidate-process pulse (bit 0 data, bit 1 instruction) |
| tlb_inv_one_p | output | 2 | Invalidate-single pulse (bit 0 data, bit 1 instruction) |
| tlb_inv_va | output | 64 | Address of the last invalidate-single write |

## Verification
The bench writes all-ones into every masked register and reads it back. A design with a wrong or missing mask would return stray high bits, or a set bit 1 in the exception address.

It also aims at direction errors:
- writing each read-only register,
- reading each write-only register,
- simultaneous read and write strobes.

A decoder that let any of these through would miss the fault flag. It could also corrupt a scratch value that is read back afterwards.

The side-effect pulses are checked for the right buffer bit, for a one-cycle width, and for silence on faulting accesses. A design that gated them wrongly would invalidate a buffer when it should not.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam int IDX_W   = 8;
    localparam int DW      = 64;
    localparam int SCR_MAX = 24;

    localparam logic [IDX_W-1:0] IX_PBASE   = 8'h18;
    localparam logic [IDX_W-1:0] IX_EXCADR  = 8'h19;
    localparam logic [IDX_W-1:0] IX_ASTREQ  = 8'h1A;
    localparam logic [IDX_W-1:0] IX_ASTEN   = 8'h1B;
    localparam logic [IDX_W-1:0] IX_IPL     = 8'h1C;
    localparam logic [IDX_W-1:0] IX_CURMODE = 8'h1D;
    localparam logic [IDX_W-1:0] IX_ALTMODE = 8'h1E;
    localparam logic [IDX_W-1:0] IX_SWIRQ   = 8'h1F;
    localparam logic [IDX_W-1:0] IX_CMODE   = 8'h20;
    localparam logic [IDX_W-1:0] IX_MBMODE  = 8'h21;
    localparam logic [IDX_W-1:0] IX_EXCSUM  = 8'h22;
    localparam logic [IDX_W-1:0] IX_EXCMSK  = 8'h23;
    localparam logic [IDX_W-1:0] IX_MODECTL = 8'h24;
    localparam logic [IDX_W-1:0] IX_FVA     = 8'h25;
    localparam logic [IDX_W-1:0] IX_INTID   = 8'h26;
    localparam logic [IDX_W-1:0] IX_MMSTAT  = 8'h27;
    localparam logic [IDX_W-1:0] IX_SERRCV  = 8'h28;
    localparam logic [IDX_W-1:0] IX_HWCLR   = 8'h29;
    localparam logic [IDX_W-1:0] IX_DCFL    = 8'h2A;
    localparam logic [IDX_W-1:0] IX_ICFL    = 8'h2B;
    localparam logic [IDX_W-1:0] IX_DINVA   = 8'h2C;
    localparam logic [IDX_W-1:0] IX_DINVP   = 8'h2D;
    localparam logic [IDX_W-1:0] IX_DINV1   = 8'h2E;
    localparam logic [IDX_W-1:0] IX_IINVA   = 8'h2F;
    localparam logic [IDX_W-1:0] IX_IINVP   = 8'h30;
    localparam logic [IDX_W-1:0] IX_IINV1   = 8'h31;
    localparam logic [IDX_W-1:0] IX_FIRST_UNUSED = 8'h32;

    localparam logic [DW-1:0] M_ALL  = {DW{1'b1}};
    localparam logic [DW-1:0] M_EXC  = ~64'h2;
    localparam logic [DW-1:0] M_AST  = 64'hf;
    localparam logic [DW-1:0] M_IPL  = 64'h1f;
    localparam logic [DW-1:0] M_MODE = 64'h18;
    localparam logic [DW-1:0] M_SW   = 64'h7fff0;
    localparam logic [DW-1:0] M_CM   = 64'h3f;

    typedef enum logic [2:0] {
        FX_NONE, FX_DALL, FX_DPROC, FX_DONE, FX_IALL, FX_IPROC, FX_IONE
    } fx_e;

    typedef struct packed {
        logic          rd_ok;
        logic          wr_ok;
        logic [DW-1:0] wmask;
        logic          wr_zero;
        logic          rd_unlock;
        fx_e           fx;
    } dec_t;

endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
#(
    parameter int NUM_SCRATCH = 24
) (
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec
);

    always_comb begin
        dec = '{rd_ok: 1'b0, wr_ok: 1'b0, wmask: M_ALL, wr_zero: 1'b0,
                rd_unlock: 1'b0, fx: FX_NONE};
        if (int'(idx) < NUM_SCRATCH && int'(idx) < SCR_MAX) begin
            dec.rd_ok = 1'b1;
            dec.wr_ok = 1'b1;
        end else begin
            case (idx)
                IX_PBASE, IX_MODECTL: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1;
                end
                IX_EXCADR: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = M_EXC;
                end
                IX_ASTREQ, IX_ASTEN: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = M_AST;
                end
                IX_IPL: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = M_IPL;
                end
                IX_CURMODE: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = M_MODE;
                end
                IX_ALTMODE: begin
                    dec.wr_ok = 1'b1; dec.wmask = M_MODE;
                end
                IX_SWIRQ: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = M_SW;
                end
                IX_CMODE, IX_MBMODE: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wmask = M_CM;
                end
                IX_EXCSUM, IX_EXCMSK: begin
                    dec.rd_ok = 1'b1; dec.wr_ok = 1'b1; dec.wr_zero = 1'b1;
                end
                IX_FVA: begin
                    dec.rd_ok = 1'b1; dec.rd_unlock = 1'b1;
                end
                IX_INTID, IX_MMSTAT, IX_SERRCV: begin
                    dec.rd_ok = 1'b1;
                end
                IX_HWCLR, IX_DCFL, IX_ICFL: begin
                    dec.wr_ok = 1'b1;
                end
                IX_DINVA: begin
                    dec.wr_ok = 1'b1; dec.wr_zero = 1'b1; dec.fx = FX_DALL;
                end
                IX_DINVP: begin
                    dec.wr_ok = 1'b1; dec.wr_zero = 1'b1; dec.fx = FX_DPROC;
                end
                IX_DINV1: begin
                    dec.wr_ok = 1'b1; dec.fx = FX_DONE;
                end
                IX_IINVA: begin
                    dec.wr_ok = 1'b1; dec.wr_zero = 1'b1; dec.fx = FX_IALL;
                end
                IX_IINVP: begin
                    dec.wr_ok = 1'b1; dec.wr_zero = 1'b1; dec.fx = FX_IPROC;
                end
                IX_IINV1: begin
                    dec.wr_ok = 1'b1; dec.fx = FX_IONE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ipr_scratch.sv
module ipr_scratch
    import ipr_pkg::*;
#(
    parameter int NUM = 24,
    localparam int AW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] bank_q [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_ent
        logic [DW-1:0] ent_d;

        always_comb begin
            ent_d = bank_q[g];
            if (we && int'(waddr) == g) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= ent_d;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM; i++) begin
            if (int'(raddr) == i) begin
                rdata = bank_q[i];
            end
        end
    end

endmodule

// File: rtl/ipr_unit.sv
module ipr_unit
    import ipr_pkg::*;
#(
    parameter int            NUM_SCRATCH = 24,
    parameter logic [63:0]   PBASE_RST   = 64'h0000_0000_0040_0000,
    parameter logic [63:0]   MODE_RST    = 64'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        acc_idx,
    input  logic [63:0]       acc_wdata,
    input  logic              acc_rd,
    input  logic              acc_wr,
    output logic [63:0]       rd_data,
    output logic              acc_fault,
    output logic              intr_unlock_p,
    output logic [1:0]        tlb_inv_all_p,
    output logic [1:0]        tlb_inv_proc_p,
    output logic [1:0]        tlb_inv_one_p,
    output logic [63:0]       tlb_inv_va
);

    localparam int SAW = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;

    typedef struct packed {
        logic [DW-1:0] pbase;
        logic [DW-1:0] exc_addr;
        logic [DW-1:0] ast_req;
        logic [DW-1:0] ast_en;
        logic [DW-1:0] ipl;
        logic [DW-1:0] cur_mode;
        logic [DW-1:0] sw_irq;
        logic [DW-1:0] cache_mode;
        logic [DW-1:0] mbuf_mode;
        logic [DW-1:0] exc_sum;
        logic [DW-1:0] exc_mask;
        logic [DW-1:0] mode_ctl;
        logic [DW-1:0] rdata;
        logic          fault;
        logic          unlock;
        logic [1:0]    inv_all;
        logic [1:0]    inv_proc;
        logic [1:0]    inv_one;
        logic [DW-1:0] inv_va;
    } st_t;

    st_t           st_d, st_q;
    dec_t          dec;
    logic          legal_rd, legal_wr, any_acc, is_scr;
    logic [DW-1:0] wval, rmux, scr_rdata;

    ipr_decode #(.NUM_SCRATCH(NUM_SCRATCH)) u_dec (
        .idx (acc_idx),
        .dec (dec)
    );

    assign is_scr   = int'(acc_idx) < NUM_SCRATCH;
    assign any_acc  = acc_rd | acc_wr;
    assign legal_rd = acc_rd & ~acc_wr & dec.rd_ok;
    assign legal_wr = acc_wr & ~acc_rd & dec.wr_ok;
    assign wval     = dec.wr_zero ? '0 : (acc_wdata & dec.wmask);

    ipr_scratch #(.NUM(NUM_SCRATCH)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (legal_wr & is_scr),
        .waddr (acc_idx[SAW-1:0]),
        .wdata (wval),
        .raddr (acc_idx[SAW-1:0]),
        .rdata (scr_rdata)
    );

    always_comb begin
        rmux = '0;
        if (is_scr) begin
            rmux = scr_rdata;
        end else begin
            case (acc_idx)
                IX_PBASE:   rmux = st_q.pbase;
                IX_EXCADR:  rmux = st_q.exc_addr;
                IX_ASTREQ:  rmux = st_q.ast_req;
                IX_ASTEN:   rmux = st_q.ast_en;
                IX_IPL:     rmux = st_q.ipl;
                IX_CURMODE: rmux = st_q.cur_mode;
                IX_SWIRQ:   rmux = st_q.sw_irq;
                IX_CMODE:   rmux = st_q.cache_mode;
                IX_MBMODE:  rmux = st_q.mbuf_mode;
                IX_EXCSUM:  rmux = st_q.exc_sum;
                IX_EXCMSK:  rmux = st_q.exc_mask;
                IX_MODECTL: rmux = st_q.mode_ctl;
                default:    rmux = '0;
            endcase
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.rdata    = '0;
        st_d.unlock   = 1'b0;
        st_d.inv_all  = 2'b00;
        st_d.inv_proc = 2'b00;
        st_d.inv_one  = 2'b00;
        st_d.fault    = any_acc & ~(legal_rd | legal_wr);

        if (legal_wr) begin
            case (acc_idx)
                IX_PBASE:   st_d.pbase      = wval;
                IX_EXCADR:  st_d.exc_addr   = wval;
                IX_ASTREQ:  st_d.ast_req    = wval;
                IX_ASTEN:   st_d.ast_en     = wval;
                IX_IPL:     st_d.ipl        = wval;
                IX_CURMODE: st_d.cur_mode   = wval;
                IX_SWIRQ:   st_d.sw_irq     = wval;
                IX_CMODE:   st_d.cache_mode = wval;
                IX_MBMODE:  st_d.mbuf_mode  = wval;
                IX_EXCSUM:  st_d.exc_sum    = wval;
                IX_EXCMSK:  st_d.exc_mask   = wval;
                IX_MODECTL: st_d.mode_ctl   = wval;
                default: ;
            endcase
            case (dec.fx)
                FX_DALL:  st_d.inv_all  = 2'b01;
                FX_IALL:  st_d.inv_all  = 2'b10;
                FX_DPROC: st_d.inv_proc = 2'b01;
                FX_IPROC: st_d.inv_proc = 2'b10;
                FX_DONE: begin
                    st_d.inv_one = 2'b01;
                    st_d.inv_va  = wval;
                end
                FX_IONE: begin
                    st_d.inv_one = 2'b10;
                    st_d.inv_va  = wval;
                end
                default: ;
            endcase
        end

        if (legal_rd) begin
            st_d.rdata  = rmux;
            st_d.unlock = dec.rd_unlock;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pbase    <= PBASE_RST;
            st_q.mode_ctl <= MODE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data        = st_q.rdata;
    assign acc_fault      = st_q.fault;
    assign intr_unlock_p  = st_q.unlock;
    assign tlb_inv_all_p  = st_q.inv_all;
    assign tlb_inv_proc_p = st_q.inv_proc;
    assign tlb_inv_one_p  = st_q.inv_one;
    assign tlb_inv_va     = st_q.inv_va;

endmodule

// File: rtl/ipr_unit_chk.sv
module ipr_unit_chk
    import ipr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  acc_idx,
    input logic [63:0] acc_wdata,
    input logic        acc_rd,
    input logic        acc_wr,
    input logic [63:0] rd_data,
    input logic        acc_fault,
    input logic        intr_unlock_p,
    input logic [1:0]  tlb_inv_all_p,
    input logic [1:0]  tlb_inv_proc_p,
    input logic [1:0]  tlb_inv_one_p,
    input logic [63:0] tlb_inv_va
);

    logic [6:0] fx_vec;
    assign fx_vec = {intr_unlock_p, tlb_inv_all_p, tlb_inv_proc_p, tlb_inv_one_p};

    p_fx_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fx_vec));

    p_fault_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (fx_vec == 7'd0 && rd_data == 64'd0));

    p_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && acc_idx == IX_FVA) |=> (intr_unlock_p && !acc_fault));

    p_excaddr_bit1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && acc_idx == IX_EXCADR) |=> !rd_data[1]);

    p_wo_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_wr && acc_idx >= IX_HWCLR && acc_idx <= IX_IINV1) |=> acc_fault);

    p_unknown_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && acc_idx >= IX_FIRST_UNUSED) |=> acc_fault);

    p_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_wr) |=> acc_fault);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd && !acc_wr) |=> (!acc_fault && rd_data == 64'd0 && fx_vec == 7'd0));

    p_inv_va_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_inv_one_p == 2'b00) |=> (tlb_inv_one_p != 2'b00 || $stable(tlb_inv_va)));

    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !acc_rd && acc_idx >= IX_FVA && acc_idx <= IX_SERRCV) |=> acc_fault);

endmodule

bind ipr_unit ipr_unit_chk u_chk (.*);

// File: tb/sim_ipr_unit.sv
`timescale 1ns/1ps
module sim_ipr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc_idx = '0;
    logic [63:0] acc_wdata = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [63:0] rd_data;
    logic        acc_fault;
    logic        intr_unlock_p;
    logic [1:0]  tlb_inv_all_p;
    logic [1:0]  tlb_inv_proc_p;
    logic [1:0]  tlb_inv_one_p;
    logic [63:0] tlb_inv_va;

    localparam logic [63:0] PB = 64'h0000_0000_0040_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    ipr_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .rd_data(rd_data), .acc_fault(acc_fault),
        .intr_unlock_p(intr_unlock_p), .tlb_inv_all_p(tlb_inv_all_p),
        .tlb_inv_proc_p(tlb_inv_proc_p), .tlb_inv_one_p(tlb_inv_one_p),
        .tlb_inv_va(tlb_inv_va)
    );

    typedef struct {
        string       tag;
        logic [63:0] rdata;
        logic        fault;
        logic        unlock;
        logic [1:0]  all;
        logic [1:0]  proc;
        logic [1:0]  one;
        logic        chk_va;
        logic [63:0] va;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int fails  = 0;

    function automatic exp_t mk(string tag, logic [63:0] rdata, logic fault);
        exp_t e;
        e.tag = tag; e.rdata = rdata; e.fault = fault; e.unlock = 1'b0;
        e.all = 2'b00; e.proc = 2'b00; e.one = 2'b00; e.chk_va = 1'b0; e.va = '0;
        return e;
    endfunction

    task automatic op(input logic rd, input logic wr, input logic [7:0] idx,
                      input logic [63:0] wd, input exp_t e);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; acc_idx = idx; acc_wdata = wd;
        sbq.push_back(e);
    endtask

    task automatic wr_ok(input logic [7:0] idx, input logic [63:0] wd, input string tag);
        op(1'b0, 1'b1, idx, wd, mk(tag, 64'd0, 1'b0));
    endtask

    task automatic rd_exp(input logic [7:0] idx, input logic [63:0] v, input string tag);
        op(1'b1, 1'b0, idx, 64'd0, mk(tag, v, 1'b0));
    endtask

    task automatic idle(input string tag);
        op(1'b0, 1'b0, 8'h00, 64'd0, mk(tag, 64'd0, 1'b0));
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (rd_data !== e.rdata || acc_fault !== e.fault || intr_unlock_p !== e.unlock ||
                tlb_inv_all_p !== e.all || tlb_inv_proc_p !== e.proc ||
                tlb_inv_one_p !== e.one || (e.chk_va && tlb_inv_va !== e.va)) begin
                fails++;
                $display("FAIL %s: got rd=%h flt=%b unl=%b all=%b proc=%b one=%b va=%h | exp rd=%h flt=%b unl=%b all=%b proc=%b one=%b va=%h",
                         e.tag, rd_data, acc_fault, intr_unlock_p, tlb_inv_all_p,
                         tlb_inv_proc_p, tlb_inv_one_p, tlb_inv_va, e.rdata, e.fault,
                         e.unlock, e.all, e.proc, e.one, e.va);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle("R1 idle outputs");
        rd_exp(8'h18, PB, "R1 pbase reset");
        rd_exp(8'h24, 64'h6, "R1 mode ctl reset");
        rd_exp(8'h1C, 64'd0, "R1 ipl reset");
        rd_exp(8'h05, 64'd0, "R1 scratch reset");
        rd_exp(8'h19, 64'd0, "R1 exc addr reset");

        // R2 full-width storage
        wr_ok(8'h00, 64'hA5A5_0123_4567_89AB, "R2 wr scr0");
        wr_ok(8'h17, 64'hDEAD_BEEF_CAFE_F00D, "R2 wr scr23");
        rd_exp(8'h00, 64'hA5A5_0123_4567_89AB, "R2 rd scr0");
        rd_exp(8'h17, 64'hDEAD_BEEF_CAFE_F00D, "R2 rd scr23");
        wr_ok(8'h24, ONES, "R2 wr mode ctl");
        rd_exp(8'h24, ONES, "R2 rd mode ctl");
        wr_ok(8'h18, 64'h1234_5678_9ABC_DEF0, "R2 wr pbase");
        rd_exp(8'h18, 64'h1234_5678_9ABC_DEF0, "R2 rd pbase");
        idle("R2 idle after read");

        // R3 exception address bit 1
        wr_ok(8'h19, ONES, "R3 wr ones");
        rd_exp(8'h19, 64'hFFFF_FFFF_FFFF_FFFD, "R3 rd ones");
        wr_ok(8'h19, 64'h1236, "R3 wr 1236");
        rd_exp(8'h19, 64'h1234, "R3 rd 1234");

        // R4 masks
        wr_ok(8'h1A, ONES, "R4 wr astreq"); rd_exp(8'h1A, 64'hf, "R4 astreq");
        wr_ok(8'h1B, ONES, "R4 wr asten");  rd_exp(8'h1B, 64'hf, "R4 asten");
        wr_ok(8'h1C, ONES, "R4 wr ipl");    rd_exp(8'h1C, 64'h1f, "R4 ipl");
        wr_ok(8'h1D, ONES, "R4 wr mode");   rd_exp(8'h1D, 64'h18, "R4 cur mode");
        wr_ok(8'h1F, ONES, "R4 wr swirq");  rd_exp(8'h1F, 64'h7fff0, "R4 swirq");
        wr_ok(8'h20, ONES, "R4 wr cmode");  rd_exp(8'h20, 64'h3f, "R4 cache mode");
        wr_ok(8'h21, ONES, "R4 wr mbmode"); rd_exp(8'h21, 64'h3f, "R4 mbuf mode");

        // R5 clear on write
        wr_ok(8'h22, ONES, "R5 wr exc sum"); rd_exp(8'h22, 64'd0, "R5 exc sum");
        wr_ok(8'h23, ONES, "R5 wr exc msk"); rd_exp(8'h23, 64'd0, "R5 exc mask");

        // R6 read-only
        op(1'b0, 1'b1, 8'h26, ONES, mk("R6 wr intid", 64'd0, 1'b1));
        rd_exp(8'h26, 64'd0, "R6 rd intid");
        op(1'b0, 1'b1, 8'h27, ONES, mk("R6 wr mmstat", 64'd0, 1'b1));
        op(1'b0, 1'b1, 8'h28, ONES, mk("R6 wr serrcv", 64'd0, 1'b1));
        op(1'b0, 1'b1, 8'h25, ONES, mk("R6 wr fva", 64'd0, 1'b1));
        rd_exp(8'h28, 64'd0, "R6 rd serrcv");

        // R7 write-only
        wr_ok(8'h1E, ONES, "R7 wr altmode");
        wr_ok(8'h29, ONES, "R7 wr hwclr");
        op(1'b1, 1'b0, 8'h1E, 64'd0, mk("R7 rd altmode", 64'd0, 1'b1));
        op(1'b1, 1'b0, 8'h29, 64'd0, mk("R7 rd hwclr", 64'd0, 1'b1));
        op(1'b1, 1'b0, 8'h2A, 64'd0, mk("R7 rd dcflush", 64'd0, 1'b1));
        op(1'b1, 1'b0, 8'h31, 64'd0, mk("R7 rd iinv one", 64'd0, 1'b1));

        // R8 unknown and both strobes
        op(1'b1, 1'b0, 8'h32, 64'd0, mk("R8 rd 32", 64'd0, 1'b1));
        op(1'b0, 1'b1, 8'hFF, ONES, mk("R8 wr ff", 64'd0, 1'b1));
        op(1'b1, 1'b1, 8'h00, 64'h1111, mk("R8 rd+wr scr0", 64'd0, 1'b1));
        rd_exp(8'h00, 64'hA5A5_0123_4567_89AB, "R8 scr0 unchanged");

        // R9 unlock
        e = mk("R9 rd fva", 64'd0, 1'b0); e.unlock = 1'b1;
        op(1'b1, 1'b0, 8'h25, 64'd0, e);
        idle("R9 unlock drops");

        // R10 invalidate-all / process
        e = mk("R10 dinv all", 64'd0, 1'b0); e.all = 2'b01;
        op(1'b0, 1'b1, 8'h2C, ONES, e);
        e = mk("R10 dinv proc", 64'd0, 1'b0); e.proc = 2'b01;
        op(1'b0, 1'b1, 8'h2D, ONES, e);
        e = mk("R10 iinv all", 64'd0, 1'b0); e.all = 2'b10;
        op(1'b0, 1'b1, 8'h2F, ONES, e);
        e = mk("R10 iinv proc", 64'd0, 1'b0); e.proc = 2'b10;
        op(1'b0, 1'b1, 8'h30, ONES, e);
        idle("R12 pulse one cycle");

        // R11 invalidate-single
        e = mk("R11 dinv one", 64'd0, 1'b0); e.one = 2'b01; e.chk_va = 1'b1;
        e.va = 64'h0000_1234_5678_9000;
        op(1'b0, 1'b1, 8'h2E, 64'h0000_1234_5678_9000, e);
        e = mk("R11 iinv one", 64'd0, 1'b0); e.one = 2'b10; e.chk_va = 1'b1;
        e.va = 64'hFFFF_0000_ABCD_E000;
        op(1'b0, 1'b1, 8'h31, 64'hFFFF_0000_ABCD_E000, e);
        e = mk("R11 va held", 64'd0, 1'b0); e.chk_va = 1'b1;
        e.va = 64'hFFFF_0000_ABCD_E000;
        op(1'b0, 1'b0, 8'h00, 64'd0, e);

        // R12 faults raise no pulse
        op(1'b1, 1'b0, 8'h2C, 64'd0, mk("R12 rd dinv all", 64'd0, 1'b1));
        op(1'b1, 1'b1, 8'h2E, ONES, mk("R12 rd+wr dinv one", 64'd0, 1'b1));
        op(1'b1, 1'b1, 8'h25, 64'd0, mk("R12 rd+wr fva", 64'd0, 1'b1));
        idle("R12 final idle");

        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0;
        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL drain: got %0d items left, expected 0", sbq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule